// File: doc/BRIEF.md
# Frame BIP-8 Parity Generator

This block sits on the transmit side of a cell-carrying framer. It watches a stream of octets. For each frame it computes a bit-interleaved even parity byte: result bit i is the XOR of bit i of every octet in the frame. A frame is 12 rows of 54 octets, so 648 octets in all. The result for frame N is held steady on the output for the whole of frame N+1. The overhead inserter downstream copies it into that frame's parity byte position.

The first octet of a frame is marked by a start strobe that comes with its valid strobe. Valid-low cycles inside a frame are skipped. A strobe that arrives before a frame has its full octet count is reported as a short frame, and the partial parity is thrown away. A test input complements the result that is latched when a frame completes. This gives deliberate parity errors for equipment testing.

Top module: `fbip_gen`

## Requirements
- R1: After reset, `par_o` is 00h, and `par_vld_o` and `short_err_o` are low.
- R2: A frame starts with the octet accepted while `vld_i` and `sof_i` are both high. It contains the next 648 octets accepted with `vld_i` high, including that first one. Cycles with `vld_i` low add nothing.
- R3: Bit i of the published result (bit 7 = MSB) is the even parity (XOR) of bit i of all 648 octets of the frame.
- R4: The result appears on `par_o` in the cycle right after the clock edge that accepts the 648th octet. It then stays unchanged until the next frame completes.
- R5: `par_vld_o` rises together with the first published result and stays high until reset.
- R6: If an octet with `sof_i` high is accepted while a frame is still short of 648 octets, `short_err_o` is high for exactly the next cycle. `par_o` keeps its previous value, the partial parity is discarded, and the strobed octet starts a new frame.
- R7: Octets are ignored before the first start strobe and between a completed frame and the next start strobe. They leave `par_o` unchanged and do not enter the next result.
- R8: If `err_inj_i` is high in the cycle the 648th octet is accepted, the published byte is the bitwise complement of the true parity. This affects only that one result.
- R9: A start strobe on the first octet after a completed frame raises no `short_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Marks the current octet as the first of a frame (qualified by `vld_i`) |
| vld_i | input | 1 | Octet on `data_i` is valid this cycle |
| data_i | input | 8 | Stream octet |
| err_inj_i | input | 1 | Complement the result latched this cycle |
| par_o | output | 8 | Parity byte of the previous complete frame |
| par_vld_o | output | 1 | A complete frame has been seen since reset |
| short_err_o | output | 1 | One-cycle pulse: a frame was cut short |

## Verification
Every result in this block is one register away from the edge that causes it. A new `par_o` value and the first rise of `par_vld_o` appear in the cycle after the 648th octet is accepted. A `short_err_o` pulse appears in the cycle after the early start strobe and lasts one cycle. The bench drives inputs on the falling edge and updates a queue-based model right after each rising edge. It then compares all three outputs on the following falling edge, so each expectation is checked in exactly the cycle it falls due. Sequences cover gapped valid strobes, back-to-back frames, stray octets outside frames, a cut-short frame, and an injected error.

// File: rtl/fbip_pkg.sv
package fbip_pkg;
    localparam int unsigned FBIP_ROWS   = 12;
    localparam int unsigned FBIP_COLS   = 54;
    localparam int unsigned FBIP_BYTE_W = 8;

    function automatic int unsigned fbip_cnt_w(input int unsigned len);
        return $clog2(len + 1);
    endfunction
endpackage

// File: rtl/fbip_octet_ctr.sv
module fbip_octet_ctr #(
    parameter int unsigned FRAME_LEN = 648,
    localparam int unsigned CW = fbip_pkg::fbip_cnt_w(FRAME_LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic sof_i,
    output logic take_o,
    output logic first_o,
    output logic last_o,
    output logic short_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          act;
    } ctr_t;

    ctr_t          st_d, st_q;
    logic [CW-1:0] idx;

    always_comb begin
        idx     = sof_i ? '0 : st_q.cnt;
        first_o = vld_i && sof_i;
        take_o  = vld_i && (sof_i || st_q.act);
        last_o  = take_o && (idx == CW'(FRAME_LEN - 1));
        short_o = first_o && st_q.act;
        st_d    = st_q;
        if (take_o) begin
            if (last_o) begin
                st_d.cnt = '0;
                st_d.act = 1'b0;
            end else begin
                st_d.cnt = idx + CW'(1);
                st_d.act = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(FRAME_LEN));
    p_sof_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && sof_i) |=> (st_q.act && st_q.cnt == CW'(1)));
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.act |-> (st_q.cnt == '0));
endmodule

// File: rtl/fbip_xor_acc.sv
module fbip_xor_acc #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take_i,
    input  logic         first_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] sum_o
);
    typedef struct packed {
        logic [W-1:0] acc;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        sum_o = (first_i ? '0 : acc_q.acc) ^ data_i;
        acc_d = acc_q;
        if (take_i) acc_d.acc = sum_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(acc_q));
endmodule

// File: rtl/fbip_result_reg.sv
module fbip_result_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         last_i,
    input  logic         short_i,
    input  logic         inj_i,
    input  logic [W-1:0] sum_i,
    output logic [W-1:0] par_o,
    output logic         valid_o,
    output logic         short_err_o
);
    typedef struct packed {
        logic [W-1:0] par;
        logic         vld;
        logic         shrt;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d      = res_q;
        res_d.shrt = short_i;
        if (last_i) begin
            res_d.par = sum_i ^ {W{inj_i}};
            res_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign par_o       = res_q.par;
    assign valid_o     = res_q.vld;
    assign short_err_o = res_q.shrt;

    p_valid_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);
    p_out_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i |=> $stable(par_o));
    p_zero_before_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (par_o == '0));
endmodule

// File: rtl/fbip_gen.sv
module fbip_gen #(
    parameter int unsigned ROWS = fbip_pkg::FBIP_ROWS,
    parameter int unsigned COLS = fbip_pkg::FBIP_COLS,
    parameter int unsigned W    = fbip_pkg::FBIP_BYTE_W,
    localparam int unsigned FRAME_LEN = ROWS * COLS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sof_i,
    input  logic         vld_i,
    input  logic [W-1:0] data_i,
    input  logic         err_inj_i,
    output logic [W-1:0] par_o,
    output logic         par_vld_o,
    output logic         short_err_o
);
    logic         take, first, last, short_fr;
    logic [W-1:0] sum;

    fbip_octet_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .sof_i(sof_i),
        .take_o(take), .first_o(first), .last_o(last), .short_o(short_fr)
    );

    fbip_xor_acc #(.W(W)) u_acc (
        .clk(clk), .rst_n(rst_n), .take_i(take), .first_i(first),
        .data_i(data_i), .sum_o(sum)
    );

    fbip_result_reg #(.W(W)) u_res (
        .clk(clk), .rst_n(rst_n), .last_i(last), .short_i(short_fr),
        .inj_i(err_inj_i), .sum_i(sum), .par_o(par_o),
        .valid_o(par_vld_o), .short_err_o(short_err_o)
    );

    p_short_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        short_err_o |-> $stable(par_o));
endmodule

// File: tb/fbip_gen_tb.sv
module fbip_gen_tb;
    localparam int FRAME = 648;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sof_i = 1'b0, vld_i = 1'b0, err_inj_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic [7:0] par_o;
    logic       par_vld_o, short_err_o;

    int n_run = 0, n_fail = 0, cyc = 0;

    logic [7:0] q[$];
    bit         m_act = 0;
    logic [7:0] m_out = 8'h00;
    bit         m_vld = 0, m_short = 0;

    always #4 clk = ~clk;

    fbip_gen u_dut (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .vld_i(vld_i), .data_i(data_i),
        .err_inj_i(err_inj_i), .par_o(par_o), .par_vld_o(par_vld_o),
        .short_err_o(short_err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_step(input bit v, input bit s, input logic [7:0] d, input bit inj);
        logic [7:0] p;
        m_short = 0;
        if (v) begin
            if (s) begin
                if (m_act && q.size() > 0) m_short = 1;
                q.delete();
                m_act = 1;
            end
            if (m_act) begin
                q.push_back(d);
                if (q.size() == FRAME) begin
                    p = 8'h00;
                    foreach (q[k]) p = p ^ q[k];
                    m_out = inj ? ~p : p;
                    m_vld = 1;
                    m_act = 0;
                    q.delete();
                end
            end
        end
    endtask

    task automatic step(input bit v, input bit s, input logic [7:0] d, input bit inj);
        vld_i = v; sof_i = s; data_i = d; err_inj_i = inj;
        @(posedge clk);
        cyc++;
        model_step(v, s, d, inj);
        @(negedge clk);
        check("R3/R4 par_o", par_o, m_out);
        check("R5 par_vld_o", par_vld_o, m_vld);
        check("R6/R9 short_err_o", short_err_o, m_short);
    endtask

    function automatic logic [7:0] pat(input int i, input int k);
        return 8'((i * 73 + k * 11) ^ (i >> 3) ^ (k << 5));
    endfunction

    // Sends n octets starting with a strobe; gap inserts a valid-low cycle every 7th octet (R2).
    task automatic frame(input int n, input int k, input bit gap, input bit inj_last);
        for (int i = 0; i < n; i++) begin
            if (gap && (i % 7 == 3)) step(0, 0, 8'hA5, 0);
            step(1, i == 0, pat(i, k), inj_last && (i == n - 1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        check("R1 par_o reset", par_o, 8'h00);
        check("R1 par_vld_o reset", par_vld_o, 0);
        check("R1 short_err_o reset", short_err_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: octets before any start strobe are ignored
        for (int i = 0; i < 20; i++) step(1, 0, 8'hFF - 8'(i), 0);
        check("R7 pre-frame par_o", par_o, 8'h00);
        frame(FRAME, 1, 1, 0);               // R2 gapped frame, R3 parity
        check("R5 valid after first frame", par_vld_o, 1);
        frame(FRAME, 2, 0, 1);               // R9 back-to-back, R8 inject
        frame(FRAME, 3, 0, 0);               // R8 inject affects one result only
        for (int i = 0; i < 30; i++) step(1, 0, 8'h5A + 8'(i), 0);   // R7 stray octets
        check("R7 stray par_o", par_o, m_out);
        frame(100, 4, 0, 0);                 // cut short
        frame(FRAME, 5, 1, 0);               // R6 new frame from the strobe
        frame(FRAME, 6, 0, 0);
        for (int i = 0; i < 4; i++) step(1, i == 0, 8'hFF, 0);    // start then idle
        for (int i = 0; i < 3; i++) step(0, 0, 8'h00, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule